// File: doc/BRIEF.md
# Scratchpad EEPROM Command Controller

This block is the memory-command layer of a 512-byte nonvolatile store. Writes to the store go through a 32-byte staging buffer (the scratchpad). The layer that handles bus framing and device selection hands the block one event at a time: a master-written bit (`wr_stb` with `wr_bit`), a request for a read slot (`rd_req`), or a bus reset. Bytes travel least significant bit first. The first byte after a bus reset is the command.

The block supports three commands:
- **Fill the scratchpad (0Fh).** The master sends a 16-bit target address and then data. The block computes a CRC-16 over the whole transfer.
- **Read the scratchpad back (AAh).** The block returns the address registers, a status byte and the buffered data.
- **Commit the scratchpad to memory (55h).** The master must first echo back the two address bytes and the status byte. Only then does the block move the buffered bytes to main memory, one byte per cycle, through a simple write port. `busy` is held high for a parameterised number of cycles, which models the programming time.

The status byte (E/S) is laid out as follows:
- bit 7 (AA): set when an authorization succeeds.
- bit 6: reads as 0.
- bit 5 (PF): set when the last fill ended with an incomplete byte.
- bits 4:0 (E): the offset of the last complete byte that was stored.

Top module: `scp_ctrl`

## Requirements
- R1: After `rst`, `busy`, `mem_we` and `rd_valid` are 0. A read-back returns 00h for both address bytes, the status byte and the scratchpad data.
- R2: Bits are assembled least significant bit first. The first 8 written bits after a bus reset form the command: 0Fh fill, AAh read-back, 55h commit.
- R3: A fill captures address byte A0 unchanged. Address byte A1 is stored with bits 7:1 forced to 0, so only address bits 8:0 survive. Both bytes are read back as stored.
- R4: Fill data is stored from offset A0[4:0] upward. E is set to the offset of the last complete byte, or to A0[4:0] if no byte completes. A trailing incomplete byte is not stored and sets PF (bit 5). Ending on a byte boundary leaves PF at 0.
- R5: The CRC starts at 0 and absorbs 0Fh, A0, A1 as sent, then every stored data byte. It shifts least significant bit first with polynomial x^16+x^15+x^2+1 (A001h in reflected form). Once the byte at offset 31 is stored, further written bits are ignored. The next 16 read slots return the inverted CRC, low byte first, least significant bit first. Later read slots return 1.
- R6: A read-back returns A0, A1, the status byte, then the scratchpad bytes from offset A0[4:0] up to offset 31. Every later slot returns 1.
- R7: A commit whose three echoed bytes equal A0, A1 and the status byte, in that order, has the following effects:
  - AA is set.
  - Each scratchpad byte from offset A0[4:0] to E is written to address {A1[0], A0[7:5], offset}.
  - `busy` stays high for exactly COPY_CYCLES cycles.
- R8: A commit with any mismatching echo byte writes nothing and never raises `busy`. All later read slots return 1.
- R9: After a commit completes, read slots return 0, 1, 0, 1 and so on (one byte reads as AAh) until a bus reset.
- R10: A new fill clears AA.
- R11: An unknown command makes the block ignore written bits and return 1 on every read slot until a bus reset.
- R12: Every `rd_req` that is not accompanied by `wr_stb` or an accepted bus reset yields `rd_valid` high, with the data on `rd_bit`, in the following cycle only.
- R13: A bus reset while `busy` is high is ignored. The commit still writes every byte and runs its full duration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset | input | 1 | Bus reset event; ends the current command |
| wr_stb | input | 1 | A master-written bit is present |
| wr_bit | input | 1 | Value of the written bit |
| rd_req | input | 1 | Master opens a read slot |
| rd_valid | output | 1 | Read-slot answer is valid |
| rd_bit | output | 1 | Read-slot answer |
| busy | output | 1 | Commit to main memory in progress |
| mem_we | output | 1 | Main-memory write enable |
| mem_addr | output | ADDR_W | Main-memory byte address |
| mem_wdata | output | 8 | Main-memory write data |

## Verification
The fill command is tried in several variants, and each one separates a different field update:
- A start offset of zero versus one in mid-page.
- A high address byte with stray upper bits versus a clean one.
- Data that ends on a byte boundary versus data that ends with 3, 4 or 7 extra bits, including a fill with no complete byte at all.

A fill that runs to offset 31 shows the switch to CRC output and the all-ones tail of the read-back. Commits are tried with a correct echo, with a correct echo after AA is already set, and with a wrong status byte. These show that the echo is compared against the live status byte, including AA. An unknown command followed by a valid fill opcode shows that the stray bits change nothing.

// File: rtl/scp_pkg.sv
package scp_pkg;

    localparam int BYTE_W = 8;
    localparam int CRC_W  = 16;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 16'hA001;

    localparam logic [BYTE_W-1:0] OP_FILL  = 8'h0F;
    localparam logic [BYTE_W-1:0] OP_READ  = 8'hAA;
    localparam logic [BYTE_W-1:0] OP_COMMIT = 8'h55;

    typedef enum logic [3:0] {
        ST_CMD,
        ST_ADR_LO,
        ST_ADR_HI,
        ST_FILL,
        ST_CRC_OUT,
        ST_READOUT,
        ST_AUTH,
        ST_COMMIT,
        ST_DONE,
        ST_MUTE
    } ctl_state_e;

    typedef struct packed {
        logic       auth_ok;
        logic       zero;
        logic       partial;
        logic [4:0] end_off;
    } status_t;

    function automatic logic [CRC_W-1:0] crc_step_byte(
        input logic [CRC_W-1:0]  c_in,
        input logic [BYTE_W-1:0] d
    );
        logic [CRC_W-1:0] c;
        c = c_in;
        for (int i = 0; i < BYTE_W; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY_REFL;
            else             c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/scp_rx.sv
module scp_rx
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              stb,
    input  logic              din,
    output logic              byte_done,
    output logic [BYTE_W-1:0] byte_val
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [BYTE_W-2:0] shreg;
    logic [CNT_W-1:0]  cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (stb) begin
            shreg <= {din, shreg[BYTE_W-2:1]};
            cnt   <= cnt + 1'b1;
        end
    end

    always_comb begin
        byte_done = stb && (cnt == CNT_W'(BYTE_W - 1));
        byte_val  = {din, shreg};
    end

endmodule

// File: rtl/scp_crc16.sv
module scp_crc16
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              upd,
    input  logic [BYTE_W-1:0] din,
    output logic [CRC_W-1:0]  crc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            crc <= '0;
        end else if (clr) begin
            crc <= upd ? crc_step_byte('0, din) : '0;
        end else if (upd) begin
            crc <= crc_step_byte(crc, din);
        end
    end
endmodule

// File: rtl/scp_pad.sv
module scp_pad
    import scp_pkg::*;
#(
    parameter int OFF_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [OFF_W-1:0]  waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [OFF_W-1:0]  raddr,
    output logic [BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << OFF_W;

    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/scp_ctrl.sv
module scp_ctrl
    import scp_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int OFF_W       = 5,
    parameter int COPY_CYCLES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_reset,
    input  logic              wr_stb,
    input  logic              wr_bit,
    input  logic              rd_req,
    output logic              rd_valid,
    output logic              rd_bit,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata
);
    localparam int PAGE_BYTES = 1 << OFF_W;
    localparam int HDR_BYTES  = 3;
    localparam int SEQ_MAX    = HDR_BYTES + PAGE_BYTES;
    localparam int SEQ_W      = $clog2(SEQ_MAX + 1) + 1;
    localparam int CNT_W      = $clog2(COPY_CYCLES + 1);
    localparam int BIT_W      = $clog2(BYTE_W);
    localparam int CIDX_W     = $clog2(CRC_W) + 1;
    localparam logic [BYTE_W-1:0] HI_MASK = BYTE_W'((1 << (ADDR_W - BYTE_W)) - 1);

    ctl_state_e        state;
    logic [BYTE_W-1:0] adr_lo, adr_hi;
    logic              auth_ok, partial;
    logic [OFF_W-1:0]  end_off, wptr, cp_off;
    logic              cp_fin;
    logic [CNT_W-1:0]  cp_cnt;
    logic [SEQ_W-1:0]  rseq;
    logic [BIT_W-1:0]  rbit;
    logic [CIDX_W-1:0] cidx;
    logic              alt;
    logic [1:0]        auth_idx;

    logic              rx_clr, rx_done, byte_ev;
    logic [BYTE_W-1:0] rx_byte;
    logic              crc_clr, crc_upd;
    logic [CRC_W-1:0]  crc_val;
    logic              pad_we;
    logic [OFF_W-1:0]  pad_raddr;
    logic [BYTE_W-1:0] pad_rdata;

    status_t           stat;
    logic [BYTE_W-1:0] stat_byte, cur_byte, auth_exp;
    logic [15:0]       ta_full;
    logic [OFF_W-1:0]  t_off;
    logic [SEQ_W:0]    off_ext;

    assign busy    = (state == ST_COMMIT);
    assign rx_clr  = bus_reset && !busy;
    assign byte_ev = rx_done && !rx_clr;
    assign ta_full = {adr_hi, adr_lo};
    assign t_off   = adr_lo[OFF_W-1:0];

    always_comb begin
        stat      = '{auth_ok: auth_ok, zero: 1'b0, partial: partial, end_off: 5'(end_off)};
        stat_byte = stat;
    end

    scp_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .clr      (rx_clr),
        .stb      (wr_stb),
        .din      (wr_bit),
        .byte_done(rx_done),
        .byte_val (rx_byte)
    );

    always_comb begin
        crc_clr = byte_ev && (state == ST_CMD) && (rx_byte == OP_FILL);
        crc_upd = crc_clr ||
                  (byte_ev && (state == ST_ADR_LO || state == ST_ADR_HI || state == ST_FILL));
        pad_we  = byte_ev && (state == ST_FILL);
    end

    scp_crc16 u_crc (
        .clk(clk),
        .rst(rst),
        .clr(crc_clr),
        .upd(crc_upd),
        .din(rx_byte),
        .crc(crc_val)
    );

    // Read-back stream: header bytes, then scratchpad from the start offset.
    always_comb begin
        off_ext   = (SEQ_W+1)'(t_off) + (SEQ_W+1)'(rseq) - (SEQ_W+1)'(HDR_BYTES);
        pad_raddr = busy ? cp_off : off_ext[OFF_W-1:0];
        if (rseq == SEQ_W'(0))      cur_byte = adr_lo;
        else if (rseq == SEQ_W'(1)) cur_byte = adr_hi;
        else if (rseq == SEQ_W'(2)) cur_byte = stat_byte;
        else if (off_ext < (SEQ_W+1)'(PAGE_BYTES)) cur_byte = pad_rdata;
        else cur_byte = '1;
        case (auth_idx)
            2'd0:    auth_exp = adr_lo;
            2'd1:    auth_exp = adr_hi;
            default: auth_exp = stat_byte;
        endcase
    end

    scp_pad #(.OFF_W(OFF_W)) u_pad (
        .clk  (clk),
        .rst  (rst),
        .we   (pad_we),
        .waddr(wptr),
        .wdata(rx_byte),
        .raddr(pad_raddr),
        .rdata(pad_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_CMD;
            adr_lo    <= '0;
            adr_hi    <= '0;
            auth_ok   <= 1'b0;
            partial   <= 1'b0;
            end_off   <= '0;
            wptr      <= '0;
            cp_off    <= '0;
            cp_fin    <= 1'b0;
            cp_cnt    <= '0;
            rseq      <= '0;
            rbit      <= '0;
            cidx      <= '0;
            alt       <= 1'b0;
            auth_idx  <= '0;
            rd_valid  <= 1'b0;
            rd_bit    <= 1'b1;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            rd_valid <= 1'b0;
            mem_we   <= 1'b0;
            if (rx_clr) begin
                state <= ST_CMD;
            end else begin
                case (state)
                    ST_CMD: if (byte_ev) begin
                        case (rx_byte)
                            OP_FILL: begin
                                auth_ok <= 1'b0;
                                state   <= ST_ADR_LO;
                            end
                            OP_READ: begin
                                rseq  <= '0;
                                rbit  <= '0;
                                state <= ST_READOUT;
                            end
                            OP_COMMIT: begin
                                auth_idx <= '0;
                                state    <= ST_AUTH;
                            end
                            default: state <= ST_MUTE;
                        endcase
                    end
                    ST_ADR_LO: if (byte_ev) begin
                        adr_lo <= rx_byte;
                        state  <= ST_ADR_HI;
                    end
                    ST_ADR_HI: if (byte_ev) begin
                        adr_hi  <= rx_byte & HI_MASK;
                        wptr    <= t_off;
                        end_off <= t_off;
                        partial <= 1'b0;
                        state   <= ST_FILL;
                    end
                    ST_FILL: if (wr_stb) begin
                        partial <= !rx_done;
                        if (rx_done) begin
                            end_off <= wptr;
                            if (wptr == '1) begin
                                cidx  <= '0;
                                state <= ST_CRC_OUT;
                            end else begin
                                wptr <= wptr + 1'b1;
                            end
                        end
                    end
                    ST_AUTH: if (byte_ev) begin
                        if (rx_byte != auth_exp) begin
                            state <= ST_MUTE;
                        end else if (auth_idx == 2'd2) begin
                            auth_ok <= 1'b1;
                            cp_off  <= t_off;
                            cp_fin  <= 1'b0;
                            cp_cnt  <= '0;
                            state   <= ST_COMMIT;
                        end else begin
                            auth_idx <= auth_idx + 1'b1;
                        end
                    end
                    ST_COMMIT: begin
                        mem_we    <= !cp_fin;
                        mem_addr  <= {ta_full[ADDR_W-1:OFF_W], cp_off};
                        mem_wdata <= pad_rdata;
                        if (!cp_fin) begin
                            if (cp_off == end_off) cp_fin <= 1'b1;
                            else                   cp_off <= cp_off + 1'b1;
                        end
                        if (cp_cnt == CNT_W'(COPY_CYCLES - 1)) begin
                            alt   <= 1'b0;
                            state <= ST_DONE;
                        end else begin
                            cp_cnt <= cp_cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase

                if (rd_req && !wr_stb) begin
                    rd_valid <= 1'b1;
                    case (state)
                        ST_CRC_OUT: begin
                            if (cidx < CIDX_W'(CRC_W)) begin
                                rd_bit <= ~crc_val[cidx[CIDX_W-2:0]];
                                cidx   <= cidx + 1'b1;
                            end else begin
                                rd_bit <= 1'b1;
                            end
                        end
                        ST_READOUT: begin
                            rd_bit <= cur_byte[rbit];
                            rbit   <= rbit + 1'b1;
                            if (rbit == '1 && rseq < SEQ_W'(SEQ_MAX)) rseq <= rseq + 1'b1;
                        end
                        ST_DONE: begin
                            rd_bit <= alt;
                            alt    <= ~alt;
                        end
                        default: rd_bit <= 1'b1;
                    endcase
                end
            end
        end
    end

    // Memory writes only happen inside an authorized commit window.
    p_we_busy_r7: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);
    p_we_auth_r8: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> auth_ok);
    p_busy_auth_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> auth_ok);
    p_page_r7: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_addr[ADDR_W-1:OFF_W] == ta_full[ADDR_W-1:OFF_W]));
    p_mute_ones_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && state == ST_MUTE && $past(state) == ST_MUTE) |-> rd_bit);
    p_busy_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (busy && bus_reset && cp_cnt != CNT_W'(COPY_CYCLES - 1)) |=> busy);

endmodule

// File: tb/scp_ctrl_test.sv
module scp_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int COPY = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_reset = 1'b0, wr_stb = 1'b0, wr_bit = 1'b0, rd_req = 1'b0;
    logic rd_valid, rd_bit, busy, mem_we;
    logic [8:0] mem_addr;
    logic [7:0] mem_wdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    scp_ctrl #(.ADDR_W(9), .OFF_W(5), .COPY_CYCLES(COPY)) uut (
        .clk(clk), .rst(rst), .bus_reset(bus_reset), .wr_stb(wr_stb), .wr_bit(wr_bit),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_bit(rd_bit), .busy(busy),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    int n_chk = 0, n_fail = 0, tim_err = 0, wcnt = 0, bcnt = 0;
    bit done_flag = 0;
    logic [7:0] bmem [512];
    logic [7:0] pat [32];

    always @(negedge clk) begin
        if (mem_we) begin
            bmem[mem_addr] <= mem_wdata;
            wcnt <= wcnt + 1;
        end
        if (busy) bcnt <= bcnt + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic brst();
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
    endtask

    task automatic wbit(input logic b);
        @(negedge clk); wr_stb = 1'b1; wr_bit = b;
        @(negedge clk); wr_stb = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) wbit(v[i]);
    endtask

    task automatic rbit(output logic b);
        @(negedge clk);
        if (rd_valid) tim_err++;
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        if (!rd_valid) tim_err++;
        b = rd_bit;
    endtask

    task automatic rbyte(output logic [7:0] v);
        logic b;
        for (int i = 0; i < 8; i++) begin
            rbit(b);
            v[i] = b;
        end
    endtask

    function automatic logic [15:0] crc_add(input logic [15:0] c_in, input logic [7:0] d);
        logic [15:0] c;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ d[i]) c = (c >> 1) ^ 16'hA001;
            else c = c >> 1;
        end
        return c;
    endfunction

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // {adr_lo, adr_hi, full bytes, trailing bits}
    localparam logic [31:0] VEC [5] = '{
        {8'h00, 8'h00, 8'd5, 8'd0},
        {8'h1C, 8'h01, 8'd3, 8'd3},
        {8'hE5, 8'hFE, 8'd2, 8'd0},
        {8'h40, 8'h03, 8'd1, 8'd7},
        {8'h0A, 8'h00, 8'd0, 8'd4}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R12 watchdog actual=hang expected=finish");
        finish_run();
    end

    initial begin
        logic [7:0] v, lo, hi, es_exp, d;
        logic [15:0] crc;
        int w0, b0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_we && !rd_valid, "R1 idle outputs", {busy, mem_we, rd_valid}, 0);

        // R1 read-back after reset
        brst(); wbyte(8'hAA);
        rbyte(v); chk(v == 8'h00, "R1 adr_lo", v, 0);
        rbyte(v); chk(v == 8'h00, "R1 adr_hi", v, 0);
        rbyte(v); chk(v == 8'h00, "R1 status", v, 0);
        rbyte(v); chk(v == 8'h00, "R1 data", v, 0);

        // R2 R3 R4 R6: table of fills, each read back
        for (int k = 0; k < 5; k++) begin
            logic [7:0] a0, a1, nb, pb;
            logic [4:0] t, e;
            {a0, a1, nb, pb} = VEC[k];
            t = a0[4:0];
            e = (nb == 0) ? t : t + 5'(nb - 1);
            es_exp = {1'b0, 1'b0, (pb != 0), e};
            brst(); wbyte(8'h0F); wbyte(a0); wbyte(a1);
            for (int j = 0; j < int'(nb); j++) wbyte(8'h5A ^ 8'(j * 19) ^ a0);
            for (int j = 0; j < int'(pb); j++) wbit(j[0]);
            brst(); wbyte(8'hAA);
            rbyte(v); chk(v == a0, "R3 adr_lo readback", v, a0);
            rbyte(v); chk(v == (a1 & 8'h01), "R3 adr_hi masked", v, a1 & 8'h01);
            rbyte(v); chk(v == es_exp, "R4 status E/PF", v, es_exp);
            for (int j = 0; j < int'(nb); j++) begin
                rbyte(v);
                chk(v == (8'h5A ^ 8'(j * 19) ^ a0), "R6 data order", v, 8'h5A ^ 8'(j * 19) ^ a0);
            end
        end

        // R5: fill to offset 31, then CRC
        for (int j = 0; j < 32; j++) pat[j] = 8'hC3 ^ 8'(j * 37);
        brst(); wbyte(8'h0F); wbyte(8'hE0); wbyte(8'h01);
        crc = crc_add(16'h0000, 8'h0F);
        crc = crc_add(crc, 8'hE0);
        crc = crc_add(crc, 8'h01);
        for (int j = 0; j < 32; j++) begin
            wbyte(pat[j]);
            crc = crc_add(crc, pat[j]);
        end
        wbyte(8'h77);
        rbyte(lo); chk(lo == ~crc[7:0], "R5 crc low", lo, ~crc[7:0]);
        rbyte(hi); chk(hi == ~crc[15:8], "R5 crc high", hi, ~crc[15:8]);
        rbyte(v); chk(v == 8'hFF, "R5 after crc", v, 8'hFF);

        // R6: read-back to end of page then ones
        brst(); wbyte(8'hAA);
        rbyte(v); rbyte(v);
        rbyte(v); chk(v == 8'h1F, "R4 status at end", v, 8'h1F);
        for (int j = 0; j < 32; j++) begin
            rbyte(v);
            chk(v == pat[j], "R6 full page", v, pat[j]);
        end
        rbyte(v); chk(v == 8'hFF, "R6 past end", v, 8'hFF);

        // R7 R9: authorized commit
        w0 = wcnt; b0 = bcnt;
        brst(); wbyte(8'h55); wbyte(8'hE0); wbyte(8'h01); wbyte(8'h1F);
        wait_idle();
        chk(wcnt - w0 == 32, "R7 write count", wcnt - w0, 32);
        chk(bcnt - b0 == COPY, "R7 busy length", bcnt - b0, COPY);
        for (int j = 0; j < 32; j++)
            chk(bmem[9'h1E0 + 9'(j)] == pat[j], "R7 memory content", bmem[9'h1E0 + 9'(j)], pat[j]);
        rbyte(v); chk(v == 8'hAA, "R9 alternating", v, 8'hAA);
        brst(); wbyte(8'hAA);
        rbyte(v); rbyte(v);
        rbyte(v); chk(v == 8'h9F, "R7 AA set", v, 8'h9F);

        // R13: commit again with AA in echo, bus reset mid-way
        w0 = wcnt; b0 = bcnt;
        brst(); wbyte(8'h55); wbyte(8'hE0); wbyte(8'h01); wbyte(8'h9F);
        repeat (10) @(negedge clk);
        bus_reset = 1'b1; @(negedge clk); bus_reset = 1'b0;
        wait_idle();
        chk(wcnt - w0 == 32, "R13 writes kept", wcnt - w0, 32);
        chk(bcnt - b0 == COPY, "R13 busy kept", bcnt - b0, COPY);

        // R10: new fill clears AA
        brst(); wbyte(8'h0F); wbyte(8'h03); wbyte(8'h00); wbyte(8'h11); wbyte(8'h22);
        brst(); wbyte(8'hAA);
        rbyte(v); rbyte(v);
        rbyte(v); chk(v == 8'h04, "R10 AA cleared", v, 8'h04);

        // R8: wrong echo
        w0 = wcnt; b0 = bcnt;
        brst(); wbyte(8'h55); wbyte(8'h03); wbyte(8'h00); wbyte(8'h05);
        repeat (4) @(negedge clk);
        rbyte(v); chk(v == 8'hFF, "R8 ones after reject", v, 8'hFF);
        chk(wcnt == w0 && bcnt == b0, "R8 no write no busy", wcnt - w0 + bcnt - b0, 0);

        // R11: unknown command ignores following bits
        brst(); wbyte(8'h99); wbyte(8'h0F); wbyte(8'h40); wbyte(8'h00);
        rbyte(v); chk(v == 8'hFF, "R11 ones", v, 8'hFF);
        brst(); wbyte(8'hAA);
        rbyte(v); chk(v == 8'h03, "R11 adr unchanged", v, 8'h03);

        chk(tim_err == 0, "R12 read timing", tim_err, 0);
        finish_run();
    end
endmodule